// File: doc/BRIEF.md
# Pipelined Radix-2 Butterfly

This block performs the core step of a radix-2 decimation-in-time transform. Each cycle it accepts two complex operands, A and B, and a complex weight w. It returns the pair A + w·B and A − w·B. All parts of the operands and the weight are 16-bit two's complement fractions: one sign bit followed by 15 fraction bits.

The block is fully pipelined, so a new operand set can enter on every clock. Each result leaves exactly five clocks after its operands entered. A valid flag travels with the data. Pipeline registers load only when they hold a live item, so the outputs keep the last result between items.

The caller is responsible for headroom. Sums wrap modulo 2^16, and no saturation is applied. The weight must stay within ±0x7FFF.

Top module: `bfly_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `vldOut` is 0 and all four result buses are 0.
- R2: An operand set presented with `vldIn` = 1 at a rising edge produces `vldOut` = 1 after exactly the fifth rising edge from that one. `vldOut` is 0 in every cycle that has no such item.
- R3: Operand sets may be presented on consecutive cycles without gaps. Each one yields exactly one result, and results come out in arrival order.
- R4: Each partial product is the full 32-bit signed product. The 16-bit value taken from it is bits [30:15], i.e. the product rescaled by 2^15 with the duplicate sign bit dropped. For example, 0x4000 × 0x4000 gives 0x2000.
- R5: The real part of w·B is the rescaled Br·wr minus the rescaled Bi·wi. The imaginary part is the rescaled Br·wi plus the rescaled Bi·wr. Both are formed modulo 2^16.
- R6: `sumRe`/`sumIm` equal A + w·B, per part, modulo 2^16.
- R7: `difRe`/`difIm` equal A − w·B, per part, modulo 2^16.
- R8: In a cycle where `vldOut` is 0, all four result buses keep the values of the most recent valid result.
- R9: When w = 0, both the sum and the difference outputs equal A exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vldIn | input | 1 | Operand set on the inputs is live |
| aRe | input | 16 | A, real part |
| aIm | input | 16 | A, imaginary part |
| bRe | input | 16 | B, real part |
| bIm | input | 16 | B, imaginary part |
| wRe | input | 16 | Weight, real part (Q15, not 0x8000) |
| wIm | input | 16 | Weight, imaginary part (Q15, not 0x8000) |
| vldOut | output | 1 | Result buses hold a new result |
| sumRe | output | 16 | A + w·B, real part |
| sumIm | output | 16 | A + w·B, imaginary part |
| difRe | output | 16 | A − w·B, real part |
| difIm | output | 16 | A − w·B, imaginary part |

## Verification
Every result is due exactly five rising edges after its operands were captured, with no other timing allowed. The driver therefore stamps each expected item with its capture cycle. The monitor, sampling on falling edges, requires that the stamp plus five equals the current cycle when it pops the item. Cycles without a valid result are checked for held outputs. Directed sets (a half-times-half product, a zero weight, extreme ±0x7FFF weights) sit among gapless random bursts and sparse traffic.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int MUL_LAT   = 4;
  localparam int ADD_LAT   = 1;
  localparam int TOTAL_LAT = MUL_LAT + ADD_LAT;

  typedef struct packed {
    logic [TOTAL_LAT-1:0] load;
  } bflyCtrl_t;
endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vldIn,
  output bflyCtrl_t ctl,
  output logic      vldOut
);
  logic [TOTAL_LAT-1:0] vldPipe;
  logic [2:0]           sinceRst;

  always_ff @(posedge clk) begin
    if (rst) vldPipe <= '0;
    else     vldPipe <= {vldPipe[TOTAL_LAT-2:0], vldIn};
  end

  always_comb begin
    ctl.load = {vldPipe[TOTAL_LAT-2:0], vldIn};
  end

  assign vldOut = vldPipe[TOTAL_LAT-1];

  always_ff @(posedge clk) begin
    if (rst)                        sinceRst <= '0;
    else if (sinceRst < 3'd5)       sinceRst <= sinceRst + 3'd1;
  end

  // Result flag follows the accepted flag five edges later
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd5) |-> (vldOut == $past(vldIn, 5)));
endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int DW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  bflyCtrl_t     ctl,
  input  logic [DW-1:0] aRe,
  input  logic [DW-1:0] aIm,
  input  logic [DW-1:0] bRe,
  input  logic [DW-1:0] bIm,
  input  logic [DW-1:0] wRe,
  input  logic [DW-1:0] wIm,
  output logic [DW-1:0] sumRe,
  output logic [DW-1:0] sumIm,
  output logic [DW-1:0] difRe,
  output logic [DW-1:0] difIm
);
  localparam int PW   = 2 * DW;
  localparam int FRAC = DW - 1;
  localparam int SHI  = PW - 2;

  // Stage 1: operand capture
  logic signed [DW-1:0] bRe1, bIm1, wRe1, wIm1;
  // Stage 2: full products
  logic signed [PW-1:0] pRR, pII, pRI, pIR;
  // Stage 3: rescaled products
  logic [DW-1:0] tRR, tII, tRI, tIR;
  // Stage 4: complex product
  logic [DW-1:0] prodRe, prodIm;
  // A arm delay
  logic [DW-1:0] aReDly [MUL_LAT];
  logic [DW-1:0] aImDly [MUL_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      bRe1 <= '0; bIm1 <= '0; wRe1 <= '0; wIm1 <= '0;
    end else if (ctl.load[0]) begin
      bRe1 <= bRe; bIm1 <= bIm; wRe1 <= wRe; wIm1 <= wIm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pRR <= '0; pII <= '0; pRI <= '0; pIR <= '0;
    end else if (ctl.load[1]) begin
      pRR <= bRe1 * wRe1;
      pII <= bIm1 * wIm1;
      pRI <= bRe1 * wIm1;
      pIR <= bIm1 * wRe1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tRR <= '0; tII <= '0; tRI <= '0; tIR <= '0;
    end else if (ctl.load[2]) begin
      tRR <= pRR[SHI:FRAC];
      tII <= pII[SHI:FRAC];
      tRI <= pRI[SHI:FRAC];
      tIR <= pIR[SHI:FRAC];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prodRe <= '0; prodIm <= '0;
    end else if (ctl.load[3]) begin
      prodRe <= tRR - tII;
      prodIm <= tRI + tIR;
    end
  end

  for (genvar k = 0; k < MUL_LAT; k++) begin : g_aDelay
    always_ff @(posedge clk) begin
      if (rst) begin
        aReDly[k] <= '0;
        aImDly[k] <= '0;
      end else if (ctl.load[k]) begin
        if (k == 0) begin
          aReDly[k] <= aRe;
          aImDly[k] <= aIm;
        end else begin
          aReDly[k] <= aReDly[(k == 0) ? 0 : k-1];
          aImDly[k] <= aImDly[(k == 0) ? 0 : k-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumRe <= '0; sumIm <= '0; difRe <= '0; difIm <= '0;
    end else if (ctl.load[MUL_LAT]) begin
      sumRe <= aReDly[MUL_LAT-1] + prodRe;
      sumIm <= aImDly[MUL_LAT-1] + prodIm;
      difRe <= aReDly[MUL_LAT-1] - prodRe;
      difIm <= aImDly[MUL_LAT-1] - prodIm;
    end
  end

  // Outputs frozen when no result is being written
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.load[MUL_LAT] |=> ($stable(sumRe) && $stable(sumIm) &&
                            $stable(difRe) && $stable(difIm)));

  // Sum and difference share the A arm: their total is twice A
  assert_sumdif_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.load[MUL_LAT] |=> ((DW'(sumRe + difRe) == DW'({$past(aReDly[MUL_LAT-1]), 1'b0})) &&
                           (DW'(sumIm + difIm) == DW'({$past(aImDly[MUL_LAT-1]), 1'b0}))));

  // A zero weight yields zero partial products
  assert_zero_weight_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl.load[1] && wRe1 == '0 && wIm1 == '0) |=>
      (pRR == '0 && pII == '0 && pRI == '0 && pIR == '0));
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
  import bfly_pkg::*;
#(
  parameter int DW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          vldIn,
  input  logic [DW-1:0] aRe,
  input  logic [DW-1:0] aIm,
  input  logic [DW-1:0] bRe,
  input  logic [DW-1:0] bIm,
  input  logic [DW-1:0] wRe,
  input  logic [DW-1:0] wIm,
  output logic          vldOut,
  output logic [DW-1:0] sumRe,
  output logic [DW-1:0] sumIm,
  output logic [DW-1:0] difRe,
  output logic [DW-1:0] difIm
);
  bflyCtrl_t ctl;

  bfly_ctrl u_ctrl (
    .clk(clk), .rst(rst), .vldIn(vldIn), .ctl(ctl), .vldOut(vldOut)
  );

  bfly_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm)
  );

  // Input weight must never be the most negative code
  assert_weight_range_R4: assert property (@(posedge clk) disable iff (rst)
    vldIn |-> (wRe != {1'b1, {(DW-1){1'b0}}} && wIm != {1'b1, {(DW-1){1'b0}}}));
endmodule

// File: tb/tb_bfly_unit.sv
module tb_bfly_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vldIn = 1'b0;
  logic [15:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0, wRe = '0, wIm = '0;
  logic vldOut;
  logic [15:0] sumRe, sumIm, difRe, difIm;

  always #4 clk = ~clk;

  bfly_unit dut (
    .clk(clk), .rst(rst), .vldIn(vldIn),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .vldOut(vldOut), .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm)
  );

  typedef struct {
    int          cyc;
    string       tag;
    logic [15:0] sr, si, dr, di;
  } item_t;

  item_t expQ[$];
  int checks = 0, errors = 0, cycle = 0;
  logic seenValid = 1'b0;
  logic [15:0] lastSr, lastSi, lastDr, lastDi;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // bits [30:15] of the signed 32-bit product (R4)
  function automatic logic [15:0] rescale(input logic [15:0] x, input logic [15:0] y);
    logic signed [31:0] p;
    p = $signed(x) * $signed(y);
    return p[30:15];
  endfunction

  task automatic drive(input logic [15:0] ar, ai, br, bi, wr, wi, input string tag);
    item_t it;
    logic [15:0] pr, pi;
    @(negedge clk);
    aRe = ar; aIm = ai; bRe = br; bIm = bi; wRe = wr; wIm = wi; vldIn = 1'b1;
    pr = rescale(br, wr) - rescale(bi, wi);   // R5
    pi = rescale(br, wi) + rescale(bi, wr);
    it.cyc = cycle; it.tag = tag;
    it.sr = ar + pr; it.si = ai + pi; it.dr = ar - pr; it.di = ai - pi;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vldIn = 1'b0;
      aRe = 16'hDEAD; bRe = 16'hBEEF; wRe = 16'h1234;
    end
  endtask

  function automatic logic [15:0] rndW();
    logic [15:0] v;
    v = 16'($urandom);
    if (v == 16'h8000) v = 16'h8001;
    return v;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (vldOut) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected result: actual vldOut=1 expected 0");
        end else begin
          item_t e;
          e = expQ.pop_front();
          chk(cycle == e.cyc + 5, $sformatf("R2 latency (%s): actual cycle %0d expected %0d", e.tag, cycle, e.cyc + 5));
          chk(sumRe == e.sr && sumIm == e.si, $sformatf("R6 sum (%s): actual %h/%h expected %h/%h", e.tag, sumRe, sumIm, e.sr, e.si));
          chk(difRe == e.dr && difIm == e.di, $sformatf("R7 dif (%s): actual %h/%h expected %h/%h", e.tag, difRe, difIm, e.dr, e.di));
        end
        seenValid = 1'b1;
        lastSr = sumRe; lastSi = sumIm; lastDr = difRe; lastDi = difIm;
      end else if (seenValid) begin
        chk(sumRe == lastSr && sumIm == lastSi && difRe == lastDr && difIm == lastDi,
            $sformatf("R8 hold: actual %h %h %h %h expected %h %h %h %h",
                      sumRe, sumIm, difRe, difIm, lastSr, lastSi, lastDr, lastDi));
      end
    end
  end

  bit timedOut = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    timedOut = 1'b1;
  end

  initial begin : main
    fork
      begin
        repeat (3) @(negedge clk);
        chk(vldOut == 1'b0 && sumRe == 0 && sumIm == 0 && difRe == 0 && difIm == 0,
            $sformatf("R1 in reset: actual vld=%b sum=%h dif=%h expected 0", vldOut, sumRe, difRe));
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(vldOut == 1'b0 && sumRe == 0 && difIm == 0,
            $sformatf("R1 after reset: actual vld=%b sum=%h expected 0", vldOut, sumRe));

        // R4: half times half
        drive(16'h0000, 16'h0000, 16'h4000, 16'h0000, 16'h4000, 16'h0000, "R4");
        idle(6);
        // R5: purely imaginary parts exercising both cross terms
        drive(16'h0100, 16'hFF00, 16'h2000, 16'h3000, 16'h0000, 16'h7FFF, "R5");
        idle(6);
        // R9: zero weight
        drive(16'h1234, 16'hABCD, 16'h7000, 16'h9000, 16'h0000, 16'h0000, "R9");
        idle(6);
        chk(sumRe == 16'h1234 && difRe == 16'h1234 && sumIm == 16'hABCD && difIm == 16'hABCD,
            $sformatf("R9 zero weight: actual %h %h %h %h expected A", sumRe, difRe, sumIm, difIm));
        // extreme weights
        drive(16'h7FFF, 16'h8000, 16'h7FFF, 16'h8001, 16'h8001, 16'h7FFF, "R5");
        // R3: gapless burst
        for (int i = 0; i < 40; i++)
          drive(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), rndW(), rndW(), "R3");
        idle(3);
        // sparse traffic
        for (int i = 0; i < 30; i++) begin
          drive(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), rndW(), rndW(), "R2");
          idle(int'($urandom_range(0, 7)));
        end
        idle(10);
        chk(expQ.size() == 0, $sformatf("R3 all results delivered: actual %0d pending expected 0", expQ.size()));
      end
      begin
        wait (timedOut);
        chk(1'b0, "watchdog expired: actual hung expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule